// File: doc/BRIEF.md
# Fractional Microsecond Tick Generator

This block turns a reference clock whose frequency may not be a whole number of megahertz into a pulse once per microsecond. The divider has two parts: a whole number of reference cycles per microsecond and a fraction with a numerator of one and a programmable denominator. When the fraction is in use, the block adds one extra reference cycle to one microsecond period in every D. The average period is then exactly integer + 1/D cycles, with no drift that builds up over time.

A strap input picks one of two built-in settings at reset: 24 MHz or 19.2 MHz. Software can later write a 32-bit configuration word. The new setting takes effect cleanly at the next microsecond boundary. Besides the tick, the block keeps a free-running count of microseconds. A read port shows the divider setting that is currently in use.

Top module: `usec_tick_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the edge clears `tick` and `usec_count`, the position in the period and the fraction phase. It also discards any configuration write that is still waiting.
- R2: `tick` is high for one reference cycle at the end of each microsecond period. The first tick after reset is released comes N cycles later, where N is the length of the first period.
- R3: With a fraction field of 0, every period lasts integer field + 1 cycles. An integer field of 0 gives a tick on every cycle.
- R4: With a fraction field F > 0, periods are numbered with a phase that counts 0 to F and then wraps. The period at phase F lasts integer field + 2 cycles and every other period lasts integer field + 1. At 19.2 MHz this gives 19,19,19,19,20, so five ticks take 96 cycles.
- R5: The configuration word holds the integer field (cycles per microsecond minus one) in bits [25:16]. It holds the fraction field (denominator minus one) in bits [29:26]. At reset the setting is loaded from `strap_24m`: integer 23 and fraction 0 when the strap is 1, integer 18 and fraction 4 when it is 0.
- R6: `usec_count` goes up by one in the same cycle that `tick` is high. It holds its value in all other cycles and wraps modulo 2^CNT_W.
- R7: A setting written with `cfg_wr` takes effect when the period that is running at the time of the write ends. Applying it clears the fraction phase to 0. A write made on a period's last cycle waits for the end of the following period. A later write replaces one that is still waiting.
- R8: `cfg_rdata` shows the setting in use at its own field positions, with every other bit 0. Bits of a write outside [29:16] have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| strap_24m | input | 1 | Selects the reset setting: 1 = 24 MHz, 0 = 19.2 MHz |
| cfg_wr | input | 1 | Write strobe for a new divider setting |
| cfg_wdata | input | 32 | Configuration word to write |
| cfg_rdata | output | 32 | Divider setting currently in use |
| tick | output | 1 | One-cycle pulse at the end of each microsecond |
| usec_count | output | CNT_W | Free-running microsecond count |

## Verification
The bench builds the block with CNT_W = 6, so the counter wraps after 64 ticks. With a setting of integer 0, the wrap can then be reached within a few hundred cycles. The field widths keep their default values, so both strap settings and every fraction denominator up to 16 stay reachable. Random writes of small integer and fraction values hit the boundary cases: a write on a period's last cycle, a write that replaces one still waiting, and a period of a single cycle.

// File: rtl/usec_tick_pkg.sv
package usec_tick_pkg;
  localparam int INT_W    = 10;
  localparam int FRAC_W   = 4;
  localparam int INT_LSB  = 16;
  localparam int FRAC_LSB = INT_LSB + INT_W;

  typedef struct packed {
    logic [FRAC_W-1:0] frac;
    logic [INT_W-1:0]  whole;
  } div_cfg_t;

  function automatic div_cfg_t word_to_cfg(input logic [31:0] w);
    div_cfg_t c;
    c.whole = w[INT_LSB +: INT_W];
    c.frac  = w[FRAC_LSB +: FRAC_W];
    return c;
  endfunction

  function automatic logic [31:0] cfg_to_word(input div_cfg_t c);
    logic [31:0] w;
    w = '0;
    w[INT_LSB +: INT_W]   = c.whole;
    w[FRAC_LSB +: FRAC_W] = c.frac;
    return w;
  endfunction
endpackage

// File: rtl/usec_cfg_reg.sv
module usec_cfg_reg
  import usec_tick_pkg::*;
#(
  parameter int HI_WHOLE = 23,
  parameter int HI_FRAC  = 0,
  parameter int LO_WHOLE = 18,
  parameter int LO_FRAC  = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        strap_hi,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        boundary,
  output div_cfg_t    active,
  output logic        apply,
  output logic [31:0] rd_data
);
  localparam div_cfg_t HI_CFG = '{frac: FRAC_W'(HI_FRAC), whole: INT_W'(HI_WHOLE)};
  localparam div_cfg_t LO_CFG = '{frac: FRAC_W'(LO_FRAC), whole: INT_W'(LO_WHOLE)};

  div_cfg_t pend_q;
  logic     pend_v_q;

  assign apply   = boundary && pend_v_q;
  assign rd_data = cfg_to_word(active);

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= strap_hi ? HI_CFG : LO_CFG;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else begin
      if (apply) active <= pend_q;
      if (wr_en) begin
        pend_q   <= word_to_cfg(wr_data);
        pend_v_q <= 1'b1;
      end else if (boundary) begin
        pend_v_q <= 1'b0;
      end
    end
  end

  // R7: the setting in use changes only at a period boundary
  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(active));
  // R7: a write always leaves a setting waiting for the next boundary
  assert_write_pends_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> pend_v_q);
endmodule

// File: rtl/usec_period_ctr.sv
module usec_period_ctr #(
  parameter int INT_W  = 10,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INT_W-1:0]  whole,
  input  logic [FRAC_W-1:0] frac,
  input  logic              phase_clr,
  output logic              boundary,
  output logic              tick_q
);
  localparam int CYC_W = INT_W + 1;

  logic [CYC_W-1:0]  cyc_q;
  logic [FRAC_W-1:0] phase_q;
  logic              stretch;
  logic [CYC_W-1:0]  last_c;

  assign stretch  = (frac != '0) && (phase_q == frac);
  assign last_c   = CYC_W'(whole) + CYC_W'(stretch);
  assign boundary = (cyc_q == last_c);

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q   <= '0;
      phase_q <= '0;
      tick_q  <= 1'b0;
    end else begin
      tick_q <= boundary;
      if (boundary) begin
        cyc_q <= '0;
        if (phase_clr || stretch || frac == '0) phase_q <= '0;
        else                                     phase_q <= phase_q + 1'b1;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

  // R2: the position never runs past the end of the period
  assert_cyc_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cyc_q <= last_c);
  // R2: a tick lasts one cycle unless the period is a single cycle
  assert_tick_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    (tick_q && last_c != '0) |=> !tick_q);
  // R4: the phase stays within 0..F
  assert_phase_bound_R4: assert property (@(posedge clk) disable iff (rst)
    phase_q <= frac);
endmodule

// File: rtl/usec_counter.sv
module usec_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + 1'b1;
  end

  // R6: one step per tick, wrapping
  assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
    inc |=> count == CNT_W'($past(count) + 1'b1));
  // R6: holds between ticks
  assert_count_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(count));
endmodule

// File: rtl/usec_tick_gen.sv
module usec_tick_gen
  import usec_tick_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int HI_WHOLE = 23,
  parameter int HI_FRAC  = 0,
  parameter int LO_WHOLE = 18,
  parameter int LO_FRAC  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strap_24m,
  input  logic             cfg_wr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  output logic             tick,
  output logic [CNT_W-1:0] usec_count
);
  div_cfg_t active;
  logic     apply;
  logic     boundary;

  usec_cfg_reg #(
    .HI_WHOLE(HI_WHOLE), .HI_FRAC(HI_FRAC),
    .LO_WHOLE(LO_WHOLE), .LO_FRAC(LO_FRAC)
  ) u_cfg (
    .clk(clk), .rst(rst), .strap_hi(strap_24m),
    .wr_en(cfg_wr), .wr_data(cfg_wdata), .boundary(boundary),
    .active(active), .apply(apply), .rd_data(cfg_rdata)
  );

  usec_period_ctr #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_period (
    .clk(clk), .rst(rst), .whole(active.whole), .frac(active.frac),
    .phase_clr(apply), .boundary(boundary), .tick_q(tick)
  );

  usec_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .inc(boundary), .count(usec_count)
  );

  // R1: outputs idle in the cycle after a reset edge
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!tick && usec_count == '0));
  // R6: the count moves exactly with the tick
  assert_count_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
    tick |-> usec_count != $past(usec_count));
endmodule

// File: tb/usec_tick_gen_tb.sv
module usec_tick_gen_tb;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          strap_24m = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic          tick;
  logic [CW-1:0] usec_count;

  int checks = 0;
  int fails = 0;

  // model state
  int  m_whole, m_frac, p_whole, p_frac, pos, ph, cnt;
  bit  m_pv, tk;

  always #2 clk = ~clk;

  usec_tick_gen #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .strap_24m(strap_24m), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tick(tick),
    .usec_count(usec_count)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] word(input int w, input int f);
    return (32'(f & 15) << 26) | (32'(w & 1023) << 16);
  endfunction

  // one clock: drive at a falling edge, advance the model, compare at the next falling edge
  task automatic step(input bit r, input bit w, input logic [31:0] d);
    int len;
    rst = r; cfg_wr = w; cfg_wdata = d;
    if (r) begin
      m_whole = strap_24m ? 23 : 18;
      m_frac  = strap_24m ? 0 : 4;
      m_pv = 0; pos = 0; ph = 0; cnt = 0; tk = 0;
    end else begin
      len = m_whole + 1 + ((m_frac != 0 && ph == m_frac) ? 1 : 0);
      if (pos == len - 1) begin
        tk = 1; cnt = (cnt + 1) % (1 << CW); pos = 0;
        ph = (m_frac != 0 && ph < m_frac) ? ph + 1 : 0;
        if (m_pv) begin
          m_whole = p_whole; m_frac = p_frac; ph = 0; m_pv = 0;
        end
      end else begin
        tk = 0; pos++;
      end
      if (w) begin
        p_whole = int'(d[25:16]); p_frac = int'(d[29:26]); m_pv = 1;
      end
    end
    @(negedge clk);
    check("R2 tick", 32'(tick), 32'(tk));
    check("R6 usec_count", 32'(usec_count), 32'(cnt));
    check("R8 cfg_rdata", cfg_rdata, word(m_whole, m_frac));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, '0);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R1 / R5: reset with 19.2 MHz strap
    strap_24m = 1'b0;
    for (int i = 0; i < 3; i++) step(1, 1, 32'hFFFF_FFFF);
    check("R1 tick after reset", 32'(tick), 32'd0);
    check("R1 count after reset", 32'(usec_count), 32'd0);
    check("R5 19.2 MHz default", cfg_rdata, 32'h1012_0000);
    // R4: five ticks take 96 cycles
    idle(95);
    check("R4 count after 95 cycles", 32'(usec_count), 32'd4);
    idle(1);
    check("R4 fifth tick at cycle 96", 32'(tick), 32'd1);
    check("R4 count after 96 cycles", 32'(usec_count), 32'd5);
    idle(100);

    // R5 / R3: 24 MHz strap
    strap_24m = 1'b1;
    for (int i = 0; i < 2; i++) step(1, 0, '0);
    check("R5 24 MHz default", cfg_rdata, 32'h0017_0000);
    idle(23);
    check("R3 no tick before cycle 24", 32'(tick), 32'd0);
    idle(1);
    check("R3 tick at cycle 24", 32'(tick), 32'd1);
    idle(10);

    // R7 / R8: write with junk bits outside the fields
    step(0, 1, 32'hC803_FFFF);
    check("R7 setting not yet applied", cfg_rdata, 32'h0017_0000);
    idle(40);
    check("R8 junk bits ignored", cfg_rdata, 32'h0803_0000);
    idle(60);

    // R3 / R6: integer 0, tick every cycle, counter wraps
    step(0, 1, word(0, 0));
    idle(140);
    check("R3 tick every cycle", 32'(tick), 32'd1);
    // R7: write on a boundary cycle and a replacing write
    step(0, 1, word(2, 0));
    step(0, 1, word(1, 1));
    idle(30);
    check("R7 last write wins", cfg_rdata, word(1, 1));

    // mixed random settings
    for (int i = 0; i < 60; i++) begin
      step(0, 1, ($urandom & 32'hC000_FFFF) | word(int'($urandom_range(0, 5)), int'($urandom_range(0, 6))));
      idle(int'($urandom_range(0, 30)));
    end
    // R1: reset in the middle of a period discards a waiting write
    step(0, 1, word(7, 0));
    strap_24m = 1'b0;
    step(1, 0, '0);
    idle(50);
    check("R1 waiting write dropped", cfg_rdata, 32'h1012_0000);
    finish_run();
  end
endmodule